// File: doc/BRIEF.md
# Banked Memory Address Translator

This block turns a 12-bit instruction address field into a physical word address inside a memory split into 1024-word banks. The low ten bits give the word offset inside a bank. The top two bits choose the bank in one of four ways:

- the single erasable bank, bank 0;
- one of two fixed banks that are always reachable;
- whatever fixed bank a programmable bank-select register names.

The bank-select register is written through a one-cycle load strobe. It is the only state in the block; the rest of the decode is combinational.

Alongside the physical bank, the offset and the flat word address, the block reports three things. It says whether the target is erasable. It flags a switched access to a bank that does not exist or that is reserved for the direct codes. It splits an incoming write request into a write enable for the erasable bank or a write-protect violation for a fixed bank.

Top module: `bank_xlate`

## Requirements
- R1: `word_off` always equals `ins_addr[9:0]`, including when `range_err` is high.
- R2: Select code `ins_addr[11:10]` = 00 gives `phys_bank` = 0 and `is_erasable` = 1. Every other code gives `is_erasable` = 0.
- R3: Code 01 gives `phys_bank` = 1 and code 10 gives `phys_bank` = 2, whatever the bank register holds.
- R4: Code 11 gives `phys_bank` equal to the current bank register value.
- R5: After reset the bank register holds 3.
- R6: When `bank_ld` is high at a rising clock edge, the bank register takes `bank_din`. When `bank_ld` is low, the register keeps its value.
- R7: `range_err` is 1 exactly when the code is 11 and the bank register is below 3 or above 24.
- R8: `phys_addr` equals `phys_bank` × 1024 + `word_off`, on 15 bits.
- R9: `wr_en` = `wr_req` AND `is_erasable`. `wr_prot` = `wr_req` AND NOT `is_erasable`. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_addr | input | 12 | Instruction address field: bits 11:10 are the select code, bits 9:0 the offset |
| wr_req | input | 1 | Write request for the addressed word |
| bank_ld | input | 1 | Load strobe for the bank register |
| bank_din | input | 5 | New bank register value |
| phys_bank | output | 5 | Physical bank number |
| word_off | output | 10 | Word offset inside the bank |
| phys_addr | output | 15 | Flat physical word address |
| is_erasable | output | 1 | Target is the erasable bank |
| range_err | output | 1 | Switched access names a bank outside 3..24 |
| wr_en | output | 1 | Write enable toward erasable memory |
| wr_prot | output | 1 | Write-protect violation on a fixed bank |

## Verification
The bench builds the block with its default parameters: a 10-bit offset, a 5-bit bank register, switchable banks 3 through 24, and a reset bank of 3. A 5-bit register can name banks 0 through 31, so both error regions are reachable through the normal load port: the reserved low values 0..2 and the nonexistent banks 25..31. The highest legal bank, 24, sits right next to the first illegal one, 25. Loading values into the register also shows that the two direct fixed codes ignore it, even when it holds an illegal value.

// File: rtl/bank_xlate.sv
module bank_xlate #(
  parameter int OFF_W      = 10,
  parameter int SEL_W      = 2,
  parameter int BANK_W     = 5,
  parameter int FIRST_SW   = 3,
  parameter int LAST_BANK  = 24,
  parameter int RESET_BANK = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [OFF_W+SEL_W-1:0]  ins_addr,
  input  logic                    wr_req,
  input  logic                    bank_ld,
  input  logic [BANK_W-1:0]       bank_din,
  output logic [BANK_W-1:0]       phys_bank,
  output logic [OFF_W-1:0]        word_off,
  output logic [BANK_W+OFF_W-1:0] phys_addr,
  output logic                    is_erasable,
  output logic                    range_err,
  output logic                    wr_en,
  output logic                    wr_prot
);
  localparam int IN_W = OFF_W + SEL_W;
  localparam logic [BANK_W-1:0] LO_B  = BANK_W'(FIRST_SW);
  localparam logic [BANK_W-1:0] HI_B  = BANK_W'(LAST_BANK);
  localparam logic [BANK_W-1:0] RST_B = BANK_W'(RESET_BANK);

  logic [BANK_W-1:0] bank_q;
  logic [SEL_W-1:0]  sel;

  assign sel = ins_addr[IN_W-1:OFF_W];

  always_ff @(posedge clk) begin
    if (!rst_n)       bank_q <= RST_B;
    else if (bank_ld) bank_q <= bank_din;
  end

  always_comb begin
    case (sel)
      SEL_W'(0): phys_bank = '0;
      SEL_W'(1): phys_bank = BANK_W'(1);
      SEL_W'(2): phys_bank = BANK_W'(2);
      default:   phys_bank = bank_q;
    endcase
  end

  assign word_off    = ins_addr[OFF_W-1:0];
  assign phys_addr   = {phys_bank, word_off};
  assign is_erasable = (sel == '0);
  assign range_err   = (sel == '1) && ((bank_q < LO_B) || (bank_q > HI_B));
  assign wr_en       = wr_req && is_erasable;
  assign wr_prot     = wr_req && !is_erasable;

  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bank_ld |=> (bank_q == $past(bank_din)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_ld |=> $stable(bank_q));

  assert_direct_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_W'(1)) |-> (phys_bank == BANK_W'(1) && !range_err));

  assert_erasable_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_erasable |-> (phys_bank == '0 && !range_err && !wr_prot));

  assert_err_only_switched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> (ins_addr[IN_W-1:OFF_W] == '1 && !is_erasable));

  assert_write_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_prot));
endmodule

// File: tb/bank_xlate_bench.sv
module bank_xlate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] ins_addr = '0;
  logic        wr_req = 0;
  logic        bank_ld = 0;
  logic [4:0]  bank_din = '0;
  logic [4:0]  phys_bank;
  logic [9:0]  word_off;
  logic [14:0] phys_addr;
  logic        is_erasable, range_err, wr_en, wr_prot;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_xlate u_bank_xlate (
    .clk(clk), .rst_n(rst_n), .ins_addr(ins_addr), .wr_req(wr_req),
    .bank_ld(bank_ld), .bank_din(bank_din), .phys_bank(phys_bank),
    .word_off(word_off), .phys_addr(phys_addr), .is_erasable(is_erasable),
    .range_err(range_err), .wr_en(wr_en), .wr_prot(wr_prot)
  );

  // vector: addr[21:10] wr[9] bank[8:4] era[3] err[2] wen[1] wprot[0]
  localparam logic [21:0] VEC [0:7] = '{
    {12'h000, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    {12'h3FF, 1'b1, 5'd0, 1'b1, 1'b0, 1'b1, 1'b0},
    {12'h400, 1'b0, 5'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    {12'h5A5, 1'b1, 5'd1, 1'b0, 1'b0, 1'b0, 1'b1},
    {12'h800, 1'b0, 5'd2, 1'b0, 1'b0, 1'b0, 1'b0},
    {12'hBFF, 1'b1, 5'd2, 1'b0, 1'b0, 1'b0, 1'b1},
    {12'hC00, 1'b0, 5'd3, 1'b0, 1'b0, 1'b0, 1'b0},
    {12'hE37, 1'b1, 5'd3, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  task automatic expect_out(input string req, input logic [4:0] bank,
                            input logic era, input logic err,
                            input logic wen, input logic wp);
    logic [14:0] exp_addr;
    exp_addr = 15'(bank) * 15'd1024 + 15'(ins_addr[9:0]);
    checks++;
    if (phys_bank !== bank || word_off !== ins_addr[9:0] ||
        phys_addr !== exp_addr || is_erasable !== era ||
        range_err !== err || wr_en !== wen || wr_prot !== wp) begin
      fails++;
      $display("FAIL %s addr=%h: got bank=%0d off=%h pa=%h era=%b err=%b wen=%b wp=%b, expected bank=%0d off=%h pa=%h era=%b err=%b wen=%b wp=%b",
               req, ins_addr, phys_bank, word_off, phys_addr, is_erasable,
               range_err, wr_en, wr_prot, bank, ins_addr[9:0], exp_addr,
               era, err, wen, wp);
    end
  endtask

  task automatic load_bank(input logic [4:0] v);
    @(negedge clk);
    bank_din = v;
    bank_ld  = 1;
    @(negedge clk);
    bank_ld  = 0;
    bank_din = ~v;
  endtask

  task automatic apply(input logic [11:0] a, input logic w);
    @(negedge clk);
    ins_addr = a;
    wr_req   = w;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R5: reset value visible through switched code
    apply(12'hC12, 1'b0);
    expect_out("R5 reset bank", 5'd3, 0, 0, 0, 0);

    // R1 R2 R3 R4 R8 R9: table walk
    for (int i = 0; i < 8; i++) begin
      apply(VEC[i][21:10], VEC[i][9]);
      expect_out("R1/R2/R3/R4/R8/R9 vector", VEC[i][8:4], VEC[i][3],
                 VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R6 R7: top legal bank
    load_bank(5'd24);
    apply(12'hFFF, 1'b0);
    expect_out("R6 load 24 / R8 top address", 5'd24, 0, 0, 0, 0);

    // R6: hold while strobe low (din differs)
    @(negedge clk); @(negedge clk); #1;
    expect_out("R6 hold", 5'd24, 0, 0, 0, 0);

    // R7: first nonexistent bank
    load_bank(5'd25);
    apply(12'hC55, 1'b1);
    expect_out("R7 bank 25 err / R1 offset passes", 5'd25, 0, 1, 0, 1);

    // R3: direct fixed codes ignore an illegal register
    apply(12'h455, 1'b0);
    expect_out("R3 code01 with reg 25", 5'd1, 0, 0, 0, 0);
    apply(12'h9AA, 1'b0);
    expect_out("R3 code10 with reg 25", 5'd2, 0, 0, 0, 0);

    // R7: reserved low values
    load_bank(5'd2);
    apply(12'hC01, 1'b0);
    expect_out("R7 bank 2 switched err", 5'd2, 0, 1, 0, 0);
    load_bank(5'd0);
    apply(12'hC02, 1'b1);
    expect_out("R7 bank 0 switched err / R2 not erasable", 5'd0, 0, 1, 0, 1);

    // R7: lowest legal switched bank, R2 code00 with odd register
    load_bank(5'd3);
    apply(12'hD00, 1'b0);
    expect_out("R7 bank 3 legal", 5'd3, 0, 0, 0, 0);
    load_bank(5'd31);
    apply(12'h2AB, 1'b1);
    expect_out("R2 code00 with reg 31 / R9 write", 5'd0, 1, 0, 1, 0);
    apply(12'hFFF, 1'b0);
    expect_out("R7 bank 31 err", 5'd31, 0, 1, 0, 0);

    // R5: reset again restores 3
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    apply(12'hC00, 1'b0);
    expect_out("R5 re-reset bank", 5'd3, 0, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule